// File: doc/BRIEF.md
# NAND Flash Bus Operation Engine

This block runs one NAND flash bus phase each time the host starts it. The host first loads a command byte, an address byte, a buffer-area index and a configuration word through a small register write port. It then writes a one-hot operation code, and the engine drives the flash pins (command latch enable, address latch enable, write strobe, read strobe, chip enable and the 8-bit data bus) to perform that single phase. It sets a sticky completion flag when the phase is done.

Data phases move one area at a time between an on-chip byte buffer and the device. The buffer holds several main areas followed by the same number of spare areas. The host fills the buffer and reads it back through its own byte port. A full page is built by the host from a sequence of command, address and data operations. The engine holds off a data output until the device's ready/busy line reports ready.

Top module: `nfe_engine`

## Requirements
- R1: After reset the engine is idle: operation status reads 0, CE#, WE# and RE# are high, CLE, ALE and the bus output enable are low.
- R2: Register select 0 holds the command byte, 1 the address byte, 2 the area index, 3 the configuration word and 4 the operation word. In the operation word, bits [5:0] = 0x01 command latch, 0x02 address latch, 0x04 data input (buffer to flash), 0x08 data output (flash to buffer), 0x10 read ID, 0x20 read status. A value whose bits [5:0] are not exactly one-hot starts nothing.
- R3: A command latch gives one WE# pulse with CLE high, ALE low and the command byte on the bus.
- R4: An address latch gives one WE# pulse with ALE high, CLE low and the address byte on the bus.
- R5: Operation status bit 15 is set when a started operation finishes. It stays set until an operation word with bit 15 clear is written while idle. Writing bit 15 as 1 leaves it set.
- R6: Operation status bit 14 is high while an operation runs. An operation word written while it runs is ignored completely.
- R7: A data input sends the main bytes of the selected area in ascending order, then its spare bytes, one WE# pulse each.
- R8: With configuration bit 2 set, data input and data output move only the spare bytes of the selected area.
- R9: A data output issues no RE# pulse while R/B# is low. It stores the bytes read on each RE# pulse into the selected area: main bytes first, then spare bytes.
- R10: Read ID takes 4 bytes with RE# pulses and stores them in bytes 0 to 3 of main area 0, whatever area is selected.
- R11: Read status takes 1 byte and stores it in byte 0 of the selected area's main part, leaving the rest of the buffer unchanged.
- R12: Each WE# or RE# pulse is low for exactly LOW_CYC clocks, and the strobe stays high for at least HIGH_CYC clocks between pulses. CE# is low whenever a strobe is low.
- R13: On the host buffer port, main byte j of area a is at a*MAIN_BYTES+j, and spare byte k of area a is at AREAS*MAIN_BYTES + a*SPARE_BYTES + k. Reads return data one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| op_status | output | 16 | {done, busy, 8'b0, current op code} |
| hb_we | input | 1 | Host buffer byte write |
| hb_addr | input | AW | Host buffer byte address |
| hb_wdata | input | 8 | Host buffer write data |
| hb_rdata | output | 8 | Host buffer read data (registered) |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Flash data bus, driven value |
| nf_io_oe | output | 1 | Flash data bus output enable |
| nf_io_in | input | 8 | Flash data bus, sampled value |
| nf_rb_n | input | 1 | Flash ready (high) / busy (low) |

## Verification
Two situations are the hardest to bring about from the ports. The first is a trigger that lands while an operation is running: the bench starts a long data input, confirms the busy bit, and then writes a command-latch code partway through the transfer. The pin log must then show only the data bytes and no CLE pulse. The second is a data output issued while the device reports busy: a bench flash model holds R/B# low for several cycles after the trigger and counts any RE# pulse seen in that window. Every area in both full and spare-only modes is swept in each direction, and the whole buffer is compared against an arithmetic model after every read-back.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    typedef enum logic [5:0] {
        OP_NONE = 6'h00,
        OP_CMD  = 6'h01,
        OP_ADDR = 6'h02,
        OP_DIN  = 6'h04,
        OP_DOUT = 6'h08,
        OP_ID   = 6'h10,
        OP_STAT = 6'h20
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT_RB,
        PH_XFER
    } phase_e;

    typedef enum logic [1:0] {
        SB_IDLE,
        SB_LOW,
        SB_HIGH
    } strobe_e;

    localparam logic [2:0] RS_CMD  = 3'd0;
    localparam logic [2:0] RS_ADDR = 3'd1;
    localparam logic [2:0] RS_AREA = 3'd2;
    localparam logic [2:0] RS_CFG  = 3'd3;
    localparam logic [2:0] RS_OP   = 3'd4;

    localparam int CFG_SPARE_BIT = 2;
    localparam int DONE_BIT      = 15;
    localparam int ID_LEN        = 4;
    localparam int STAT_LEN      = 1;

    // Operations that drive the bus and use the write strobe.
    function automatic logic drives_bus(op_e op);
        return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_DIN);
    endfunction

endpackage

// File: rtl/nfe_strobe.sv
module nfe_strobe
    import nfe_pkg::*;
#(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic strobe_n,
    output logic sample,
    output logic fin,
    output logic idle
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    strobe_e        st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SB_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SB_IDLE: if (go) begin
                    st  <= SB_LOW;
                    cnt <= '0;
                end
                SB_LOW: if (cnt == CW'(LOW_CYC - 1)) begin
                    st  <= SB_HIGH;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SB_HIGH: if (cnt == CW'(HIGH_CYC - 1)) begin
                    st  <= SB_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= SB_IDLE;
            endcase
        end
    end

    assign strobe_n = (st != SB_LOW);
    assign sample   = (st == SB_LOW)  && (cnt == CW'(LOW_CYC - 1));
    assign fin      = (st == SB_HIGH) && (cnt == CW'(HIGH_CYC - 1));
    assign idle     = (st == SB_IDLE);

    // R12: a pulse request only arrives when no pulse is in flight
    assert_go_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
        go |-> (st == SB_IDLE));

    // R12: the low phase never runs past its programmed length
    assert_low_bounded_R12: assert property (@(posedge clk) disable iff (rst)
        (st == SB_LOW) |-> (cnt < CW'(LOW_CYC)));

endmodule

// File: rtl/nfe_buffer.sv
module nfe_buffer #(
    parameter int DEPTH = 2112,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic          e_we,
    input  logic [AW-1:0] e_addr,
    input  logic [7:0]    e_wdata,
    output logic [7:0]    e_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (h_we) mem[h_addr] <= h_wdata;
        if (e_we) mem[e_addr] <= e_wdata;
        h_rdata <= mem[h_addr];
    end

    assign e_rdata = mem[e_addr];

endmodule

// File: rtl/nfe_engine.sv
module nfe_engine
    import nfe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int AREAS       = 4,
    parameter int LOW_CYC     = 2,
    parameter int HIGH_CYC    = 1,
    parameter int BUF_BYTES   = AREAS * (MAIN_BYTES + SPARE_BYTES),
    parameter int AW          = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   op_status,
    input  logic          hb_we,
    input  logic [AW-1:0] hb_addr,
    input  logic [7:0]    hb_wdata,
    output logic [7:0]    hb_rdata,
    output logic          nf_ce_n,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic          nf_we_n,
    output logic          nf_re_n,
    output logic [7:0]    nf_io_out,
    output logic          nf_io_oe,
    input  logic [7:0]    nf_io_in,
    input  logic          nf_rb_n
);
    localparam int AREA_W     = (AREAS > 1) ? $clog2(AREAS) : 1;
    localparam int XFER_MAX   = MAIN_BYTES + SPARE_BYTES;
    localparam int IW         = $clog2(XFER_MAX + 1);
    localparam int SPARE_BASE = AREAS * MAIN_BYTES;

    logic [7:0]        cmd_q, addr_q;
    logic [AREA_W-1:0] area_q, xa;
    logic              spare_q, xs;
    op_e               cur_op;
    phase_e            phase;
    logic              done_q;
    logic [IW-1:0]     idx, nbytes;

    logic          op_wr, accept, busy, wr_op;
    logic          s_go, s_strobe_n, s_sample, s_fin, s_idle;
    logic          e_we;
    logic [AW-1:0] e_addr;
    logic [7:0]    e_rdata;
    logic          unused_bits;

    assign unused_bits = ^cfg_wdata[14:8];

    assign op_wr  = cfg_we && (cfg_sel == RS_OP);
    assign accept = op_wr && (phase == PH_IDLE) && $onehot(cfg_wdata[5:0]);
    assign busy   = (phase != PH_IDLE);
    assign wr_op  = drives_bus(cur_op);

    // Host-visible setup registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            area_q  <= '0;
            spare_q <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                RS_CMD:  cmd_q   <= cfg_wdata[7:0];
                RS_ADDR: addr_q  <= cfg_wdata[7:0];
                RS_AREA: area_q  <= cfg_wdata[AREA_W-1:0];
                RS_CFG:  spare_q <= cfg_wdata[CFG_SPARE_BIT];
                default: ;
            endcase
        end
    end

    // Byte count of the running operation.
    always_comb begin
        case (cur_op)
            OP_ID:          nbytes = IW'(ID_LEN);
            OP_STAT:        nbytes = IW'(STAT_LEN);
            OP_DIN, OP_DOUT: nbytes = xs ? IW'(SPARE_BYTES) : IW'(XFER_MAX);
            default:        nbytes = IW'(1);
        endcase
    end

    // Buffer byte address of the current transfer index.
    always_comb begin
        logic [31:0] off;
        off = 32'(idx);
        case (cur_op)
            OP_ID:   e_addr = AW'(off);
            OP_STAT: e_addr = AW'(32'(xa) * MAIN_BYTES);
            default: begin
                if (xs)
                    e_addr = AW'(SPARE_BASE + 32'(xa) * SPARE_BYTES + off);
                else if (off < MAIN_BYTES)
                    e_addr = AW'(32'(xa) * MAIN_BYTES + off);
                else
                    e_addr = AW'(SPARE_BASE + 32'(xa) * SPARE_BYTES + off - MAIN_BYTES);
            end
        endcase
    end

    // Operation sequencer.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cur_op <= OP_NONE;
            done_q <= 1'b0;
            idx    <= '0;
            xa     <= '0;
            xs     <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (op_wr)
                        done_q <= done_q & cfg_wdata[DONE_BIT];
                    if (accept) begin
                        cur_op <= op_e'(cfg_wdata[5:0]);
                        idx    <= '0;
                        xa     <= area_q;
                        xs     <= spare_q;
                        phase  <= (op_e'(cfg_wdata[5:0]) == OP_DOUT) ? PH_WAIT_RB : PH_XFER;
                    end
                end
                PH_WAIT_RB: if (nf_rb_n) phase <= PH_XFER;
                PH_XFER: if (s_fin) begin
                    if (idx == nbytes - IW'(1)) begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign s_go = (phase == PH_XFER) && s_idle;
    assign e_we = s_sample && !wr_op && busy;

    nfe_strobe #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_strobe (
        .clk(clk), .rst(rst), .go(s_go),
        .strobe_n(s_strobe_n), .sample(s_sample), .fin(s_fin), .idle(s_idle)
    );

    nfe_buffer #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
        .clk(clk),
        .h_we(hb_we), .h_addr(hb_addr), .h_wdata(hb_wdata), .h_rdata(hb_rdata),
        .e_we(e_we), .e_addr(e_addr), .e_wdata(nf_io_in), .e_rdata(e_rdata)
    );

    // Flash pins.
    assign nf_ce_n   = !busy;
    assign nf_cle    = busy && (cur_op == OP_CMD);
    assign nf_ale    = busy && (cur_op == OP_ADDR);
    assign nf_we_n   = (busy && wr_op)  ? s_strobe_n : 1'b1;
    assign nf_re_n   = (busy && !wr_op) ? s_strobe_n : 1'b1;
    assign nf_io_oe  = busy && wr_op;
    assign nf_io_out = (cur_op == OP_CMD)  ? cmd_q :
                       (cur_op == OP_ADDR) ? addr_q : e_rdata;

    assign op_status = {done_q, busy, 8'h00, cur_op};

    // R3: command and address latch enables never overlap
    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale));

    // R12: write and read strobes never low together
    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    // R12: chip enable covers every strobe pulse
    assert_ce_cover_R12: assert property (@(posedge clk) disable iff (rst)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

    // R5: completion flag holds unless cleared by an idle write with bit 15 low
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (done_q && !(op_wr && (phase == PH_IDLE) && !cfg_wdata[DONE_BIT])) |=> done_q);

    // R6: a trigger written mid-operation leaves the running op untouched
    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && op_wr) |=> $stable(cur_op));

    // R9: no read strobe while the device reports busy before a data output
    assert_rb_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT_RB) |-> nf_re_n);

endmodule

// File: tb/nfe_engine_test.sv
module nfe_engine_test;
    localparam int MB  = 8;
    localparam int SB  = 4;
    localparam int AR  = 4;
    localparam int LC  = 2;
    localparam int HC  = 1;
    localparam int BUF = AR * (MB + SB);
    localparam int AW  = $clog2(BUF);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   op_status;
    logic          hb_we = 1'b0;
    logic [AW-1:0] hb_addr = '0;
    logic [7:0]    hb_wdata = '0;
    logic [7:0]    hb_rdata;
    logic          nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]    nf_io_out;
    logic [7:0]    nf_io_in = '0;
    logic          nf_rb_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nfe_engine #(.MAIN_BYTES(MB), .SPARE_BYTES(SB), .AREAS(AR),
                 .LOW_CYC(LC), .HIGH_CYC(HC)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .op_status(op_status),
        .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
    );

    // Flash-side model: logs write pulses, serves read pulses, times strobes.
    logic [7:0] lg_byte [512];
    logic       lg_cle  [512];
    logic       lg_ale  [512];
    logic [7:0] served  [512];
    int lg_n = 0, sv_n = 0, we_low = 0, re_low = 0, tm_bad = 0, rb_bad = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!nf_we_n) we_low++;
            if (!nf_re_n) re_low++;
            if (prev_we && !nf_we_n && nf_ce_n) tm_bad++;
            if (!prev_we && nf_we_n) begin
                lg_byte[lg_n] = nf_io_out;
                lg_cle[lg_n]  = nf_cle;
                lg_ale[lg_n]  = nf_ale;
                lg_n++;
                if (we_low != LC) tm_bad++;
                we_low = 0;
            end
            if (prev_re && !nf_re_n) begin
                nf_io_in = 8'h3C + 8'(sv_n * 13);
                served[sv_n] = nf_io_in;
                sv_n++;
            end
            if (!prev_re && nf_re_n) begin
                if (re_low != LC) tm_bad++;
                re_low = 0;
            end
            if (!nf_re_n && !nf_rb_n) rb_bad++;
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    logic [7:0] exp_mem [BUF];

    function automatic int main_a(int a, int j); return a * MB + j; endfunction
    function automatic int spare_a(int a, int k); return AR * MB + a * SB + k; endfunction
    function automatic int xfer_a(int a, int s, int i);
        if (s != 0) return spare_a(a, i);
        if (i < MB) return main_a(a, i);
        return spare_a(a, i - MB);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_buf(input int a, input logic [7:0] d);
        @(negedge clk);
        hb_we = 1'b1; hb_addr = AW'(a); hb_wdata = d;
        @(negedge clk);
        hb_we = 1'b0;
    endtask

    task automatic rd_buf(input int a, output logic [7:0] d);
        @(negedge clk);
        hb_addr = AW'(a);
        @(negedge clk);
        d = hb_rdata;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!op_status[15] && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(op_status[15] && !op_status[14], req, op_status, 16'h8000);
    endtask

    task automatic compare_all(input string req);
        logic [7:0] d;
        for (int k = 0; k < BUF; k++) begin
            rd_buf(k, d);
            check(d == exp_mem[k], req, d, exp_mem[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base, bsv, n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(op_status == 16'h0000, "R1 status", op_status, 0);
        check({nf_ce_n, nf_we_n, nf_re_n} == 3'b111, "R1 strobes", {nf_ce_n, nf_we_n, nf_re_n}, 7);
        check({nf_cle, nf_ale, nf_io_oe} == 3'b000, "R1 latches", {nf_cle, nf_ale, nf_io_oe}, 0);

        // R13: host buffer layout, full fill and read-back
        for (int k = 0; k < BUF; k++) begin
            exp_mem[k] = 8'(k * 5 + 17);
            wr_buf(k, exp_mem[k]);
        end
        compare_all("R13 buffer");

        // R3: command latch
        base = lg_n;
        wr_reg(3'd0, 16'h0080);
        wr_reg(3'd4, 16'h0001);
        wait_done("R5 cmd done");
        check(lg_n - base == 1, "R3 pulse count", lg_n - base, 1);
        check(lg_byte[base] == 8'h80 && lg_cle[base] && !lg_ale[base], "R3 cmd byte",
              {lg_cle[base], lg_ale[base], lg_byte[base]}, 16'h0280);

        // R5: sticky done, write of 1 keeps, write of 0 clears
        repeat (5) @(negedge clk);
        check(op_status[15], "R5 sticky", op_status[15], 1);
        wr_reg(3'd4, 16'h8000);
        @(negedge clk);
        check(op_status[15], "R5 keep on 1", op_status[15], 1);

        // R2: non-one-hot codes start nothing
        base = lg_n; bsv = sv_n;
        wr_reg(3'd4, 16'h8003);
        repeat (10) @(negedge clk);
        check(!op_status[14] && lg_n == base && sv_n == bsv, "R2 bad code",
              op_status[14], 0);
        check(op_status[15], "R2 done kept", op_status[15], 1);
        wr_reg(3'd4, 16'h0000);
        @(negedge clk);
        check(!op_status[15] && !op_status[14], "R5 clear", op_status, 0);

        // R4: address latch, several values
        for (int v = 0; v < 4; v++) begin
            base = lg_n;
            wr_reg(3'd1, 16'(8'h11 + v * 8'h4B));
            wr_reg(3'd4, 16'h0002);
            wait_done("R5 addr done");
            check(lg_n - base == 1, "R4 pulse count", lg_n - base, 1);
            check(lg_byte[base] == 8'(8'h11 + v * 8'h4B) && lg_ale[base] && !lg_cle[base],
                  "R4 addr byte", lg_byte[base], 8'(8'h11 + v * 8'h4B));
        end

        // R7/R8: data input, every area, both modes
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < AR; a++) begin
                n = (s != 0) ? SB : MB + SB;
                base = lg_n;
                wr_reg(3'd2, 16'(a));
                wr_reg(3'd3, 16'(s << 2));
                wr_reg(3'd4, 16'h0004);
                wait_done("R7 din done");
                check(lg_n - base == n, (s != 0) ? "R8 din count" : "R7 din count", lg_n - base, n);
                for (int i = 0; i < n; i++)
                    check(lg_byte[base + i] == exp_mem[xfer_a(a, s, i)] && !lg_cle[base + i],
                          (s != 0) ? "R8 din byte" : "R7 din byte",
                          lg_byte[base + i], exp_mem[xfer_a(a, s, i)]);
            end
        end

        // R9/R8: data output with R/B# held low first, every area, both modes
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < AR; a++) begin
                n = (s != 0) ? SB : MB + SB;
                bsv = sv_n;
                wr_reg(3'd2, 16'(a));
                wr_reg(3'd3, 16'(s << 2));
                nf_rb_n = 1'b0;
                wr_reg(3'd4, 16'h0008);
                repeat (12) @(negedge clk);
                check(op_status[14] && sv_n == bsv, "R9 wait busy", sv_n - bsv, 0);
                nf_rb_n = 1'b1;
                wait_done("R9 dout done");
                check(sv_n - bsv == n, "R9 dout count", sv_n - bsv, n);
                for (int i = 0; i < n; i++) exp_mem[xfer_a(a, s, i)] = served[bsv + i];
                compare_all((s != 0) ? "R8 dout buffer" : "R9 dout buffer");
            end
        end
        check(rb_bad == 0, "R9 RE while busy", rb_bad, 0);

        // R10: read ID lands in main area 0 regardless of area select
        bsv = sv_n;
        wr_reg(3'd2, 16'd2);
        wr_reg(3'd4, 16'h0010);
        wait_done("R10 id done");
        check(sv_n - bsv == 4, "R10 id count", sv_n - bsv, 4);
        for (int i = 0; i < 4; i++) exp_mem[main_a(0, i)] = served[bsv + i];
        compare_all("R10 id buffer");

        // R11: read status into byte 0 of selected area
        bsv = sv_n;
        wr_reg(3'd2, 16'd3);
        wr_reg(3'd4, 16'h0020);
        wait_done("R11 stat done");
        check(sv_n - bsv == 1, "R11 stat count", sv_n - bsv, 1);
        exp_mem[main_a(3, 0)] = served[bsv];
        compare_all("R11 stat buffer");

        // R6: trigger written mid-transfer is ignored
        base = lg_n;
        wr_reg(3'd2, 16'd1);
        wr_reg(3'd3, 16'd0);
        wr_reg(3'd4, 16'h0004);
        repeat (6) @(negedge clk);
        check(op_status[14], "R6 busy bit", op_status[14], 1);
        wr_reg(3'd4, 16'h0001);
        wait_done("R6 done");
        check(lg_n - base == MB + SB, "R6 ignored trigger", lg_n - base, MB + SB);
        for (int i = 0; i < MB + SB; i++)
            check(!lg_cle[base + i], "R6 no cmd pulse", lg_cle[base + i], 0);
        check(op_status[5:0] == 6'h04, "R6 op kept", op_status[5:0], 4);

        // R12: strobe timing across the whole run
        check(tm_bad == 0, "R12 strobe timing", tm_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule